// File: doc/BRIEF.md
# DMA Request Burst Limiter

This block drives the DMA request line for a byte-wide parallel-port FIFO. It raises the request only when DMA is enabled, the service-hold bit is clear and the FIFO can take part in a transfer in the current direction. Each leading edge of the active-low acknowledge is turned into a one-cycle FIFO strobe, to the write side or the read side depending on the direction. Address inputs play no part in this.

The request is never left up for more than a fixed number of consecutive DMA cycles (32 by default). After the last cycle of a burst, the request stays down until the acknowledge has been idle for a minimum time (350 ns by default). That time is converted to clock cycles from the clock period parameter. Only a terminal count completes a transfer. It produces a completion event for the interrupt logic and blocks requests until the register logic has set the service-hold bit. Dropping the enable only pauses the transfer.

Top module: `dma_req_limiter`

## Requirements
- R1: One clock after `dma_en`=1 and `svc_hold`=0 are sampled, with the FIFO condition of R2 met and no hold-off, block or cap pending, `dreq` is 1. With `svc_hold`=1 or `dma_en`=0, `dreq` is 0 one clock later.
- R2: With `dir_rd`=0 (host to FIFO), a request needs `fifo_full`=0. With `dir_rd`=1 (FIFO to host), a request needs `fifo_empty`=0. The other flag has no effect.
- R3: If `dreq` is 1 when the 32nd acknowledge falling edge of a burst is sampled, `dreq` is 0 from the next clock.
- R4: After such a cap, `dreq` stays 0 until `dack_n` has been sampled high on HOLD consecutive clocks, where HOLD = ceil(HOLD_NS / CLK_NS) (18 at the defaults). A low sample restarts the count. `dreq` returns one clock after the HOLD-th high sample.
- R5: In the cycle where `dack_n` is first seen low after a high sample, exactly one of `fifo_wr_stb` (`dir_rd`=0) or `fifo_rd_stb` (`dir_rd`=1) is 1, for that one cycle only.
- R6: `tc_done` is 1 in the cycle where `tc`=1 coincides with an acknowledge falling edge. `dreq` is then 0 from the next clock, and stays 0 until `svc_hold` has been sampled 1.
- R7: Clearing `dma_en` drops `dreq` one clock later and never produces `tc_done`.
- R8: The burst count restarts whenever `dreq` drops for any reason, so a new run of 32 cycles is allowed after it.
- R9: While `rst_n` is 0, `dreq`, both strobes and `tc_done` are 0, and no block or hold-off is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | DMA mode enable |
| svc_hold | input | 1 | Service-hold bit; 1 blocks requests |
| dir_rd | input | 1 | 0: host writes FIFO, 1: host reads FIFO |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| dack_n | input | 1 | Active-low DMA acknowledge, synchronous to clk |
| tc | input | 1 | Terminal count, valid with the acknowledge |
| dreq | output | 1 | DMA request |
| fifo_wr_stb | output | 1 | One-cycle FIFO write strobe |
| fifo_rd_stb | output | 1 | One-cycle FIFO read strobe |
| tc_done | output | 1 | Transfer-complete event to the interrupt logic |

## Verification
`dreq` is a register, so every change on the enable, hold, direction or FIFO flag inputs shows on it one clock later. The strobes and `tc_done` follow the acknowledge edge in the same cycle. The bench drives inputs on the falling clock edge and reads `dreq` at the next falling edge. It reads the strobes and `tc_done` 1 ns after driving the acknowledge low. For the hold-off it counts the rising edges that sample `dack_n` high and expects `dreq` to stay low through the HOLD-th edge and rise on the edge after it.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  // Idle clocks needed to cover a time in ns, rounded up.
  function automatic int hold_cycles(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/dreq_ack_edge.sv
module dreq_ack_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic dack_n,
  input  logic dir_rd,
  output logic ack_fall,
  output logic wr_stb,
  output logic rd_stb
);
  logic dack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dack_q <= 1'b1;
    else        dack_q <= dack_n;
  end

  assign ack_fall = dack_q & ~dack_n;
  assign wr_stb   = ack_fall & ~dir_rd;
  assign rd_stb   = ack_fall &  dir_rd;

  // R5: only one strobe at a time, and each lasts one cycle
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_stb}));
  p_short_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_stb) |=> !(wr_stb || rd_stb));
endmodule

// File: rtl/dreq_burst_cnt.sv
module dreq_burst_cnt #(
  parameter int BURST = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq_i,
  input  logic ack_fall,
  output logic cap_hit
);
  localparam int CW = $clog2(BURST + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!dreq_i)  cnt <= '0;           // R8: restart on any drop
    else if (ack_fall) cnt <= cnt + 1'b1;
  end

  assign cap_hit = dreq_i & ack_fall & (cnt == CW'(BURST - 1));

  p_cap_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> !dreq_i);
endmodule

// File: rtl/dreq_holdoff.sv
module dreq_holdoff #(
  parameter int HOLD = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dack_n,
  output logic holdoff
);
  localparam int HW = $clog2(HOLD + 1);
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdoff <= 1'b0;
      hcnt    <= '0;
    end else if (start) begin
      holdoff <= 1'b1;
      hcnt    <= '0;
    end else if (holdoff) begin
      if (!dack_n)                     hcnt <= '0;   // R4: restart
      else if (hcnt == HW'(HOLD - 1)) begin
        holdoff <= 1'b0;
        hcnt    <= '0;
      end else                         hcnt <= hcnt + 1'b1;
    end
  end

  p_release_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdoff) |-> $past(dack_n));
endmodule

// File: rtl/dma_req_limiter.sv
module dma_req_limiter #(
  parameter int CLK_NS  = 20,
  parameter int HOLD_NS = 350,
  parameter int BURST   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic svc_hold,
  input  logic dir_rd,
  input  logic fifo_full,
  input  logic fifo_empty,
  input  logic dack_n,
  input  logic tc,
  output logic dreq,
  output logic fifo_wr_stb,
  output logic fifo_rd_stb,
  output logic tc_done
);
  localparam int HOLD = dreq_pkg::hold_cycles(HOLD_NS, CLK_NS);

  logic ack_fall, cap_hit, holdoff, blocked, fifo_ok, want;

  dreq_ack_edge u_edge (
    .clk(clk), .rst_n(rst_n), .dack_n(dack_n), .dir_rd(dir_rd),
    .ack_fall(ack_fall), .wr_stb(fifo_wr_stb), .rd_stb(fifo_rd_stb)
  );

  dreq_burst_cnt #(.BURST(BURST)) u_burst (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .ack_fall(ack_fall),
    .cap_hit(cap_hit)
  );

  dreq_holdoff #(.HOLD(HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .start(cap_hit), .dack_n(dack_n),
    .holdoff(holdoff)
  );

  assign tc_done = tc & ack_fall;
  assign fifo_ok = dir_rd ? ~fifo_empty : ~fifo_full;
  assign want    = dma_en & ~svc_hold & ~blocked & fifo_ok
                 & ~holdoff & ~cap_hit & ~tc_done;

  // Block after terminal count until the hold bit has been seen set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked <= 1'b0;
      dreq    <= 1'b0;
    end else begin
      if (tc_done)       blocked <= 1'b1;
      else if (svc_hold) blocked <= 1'b0;
      dreq <= want;
    end
  end

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> $past(dma_en && !svc_hold));
  p_quiet_in_holdoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    holdoff |-> !dreq);
  p_tc_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_done |=> !dreq);
  p_disable_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !dreq);
endmodule

// File: tb/dma_req_limiter_bench.sv
module dma_req_limiter_bench;
  localparam int CLK_NS = 20;
  localparam int HOLD_B = (350 + CLK_NS - 1) / CLK_NS;   // 18 idle clocks

  logic clk = 1'b0;
  logic rst_n, dma_en, svc_hold, dir_rd, fifo_full, fifo_empty, dack_n, tc;
  logic dreq, fifo_wr_stb, fifo_rd_stb, tc_done;
  int   n_chk = 0, n_bad = 0;
  logic last_wr, last_rd, last_tc;
  bit   done_run = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  dma_req_limiter #(.CLK_NS(CLK_NS)) u_dma_req_limiter (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .svc_hold(svc_hold),
    .dir_rd(dir_rd), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .dack_n(dack_n), .tc(tc), .dreq(dreq), .fifo_wr_stb(fifo_wr_stb),
    .fifo_rd_stb(fifo_rd_stb), .tc_done(tc_done)
  );

  // {dma_en, svc_hold, dir_rd, fifo_full, fifo_empty, expected dreq}
  localparam logic [5:0] VEC [8] = '{
    6'b100011, 6'b100100, 6'b101010, 6'b101101,
    6'b000000, 6'b110000, 6'b101001, 6'b011000 };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One DMA cycle: acknowledge low for one clock, then high. Entered at negedge.
  task automatic ack(input logic with_tc);
    dack_n = 1'b0; tc = with_tc;
    #1;
    last_wr = fifo_wr_stb; last_rd = fifo_rd_stb; last_tc = tc_done;
    @(negedge clk);
    dack_n = 1'b1; tc = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; dma_en = 1'b1; svc_hold = 1'b0; dir_rd = 1'b0;
    fifo_full = 1'b0; fifo_empty = 1'b1; dack_n = 1'b1; tc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 dreq", dreq, 1'b0);
    chk("R9 strobes", fifo_wr_stb | fifo_rd_stb, 1'b0);
    chk("R9 tc_done", tc_done, 1'b0);
    rst_n = 1'b1;
    dma_en = 1'b0;
    @(negedge clk);

    // R1/R2 table
    foreach (VEC[i]) begin
      {dma_en, svc_hold, dir_rd, fifo_full, fifo_empty} = VEC[i][5:1];
      @(negedge clk);
      chk($sformatf("R1/R2 row %0d", i), dreq, VEC[i][0]);
    end

    // R3/R4/R5: burst cap in write direction
    {dma_en, svc_hold, dir_rd, fifo_full, fifo_empty} = 5'b10001;
    @(negedge clk);
    chk("R1 start", dreq, 1'b1);
    ack(1'b0);
    chk("R5 wr strobe", last_wr, 1'b1);
    chk("R5 no rd strobe", last_rd, 1'b0);
    chk("R5 strobe one cycle", fifo_wr_stb, 1'b0);
    for (int k = 0; k < 30; k++) ack(1'b0);
    chk("R3 31 cycles kept", dreq, 1'b1);
    ack(1'b0);
    chk("R3 cap drop", dreq, 1'b0);
    repeat (HOLD_B - 1) @(negedge clk);
    chk("R4 still held", dreq, 1'b0);
    @(negedge clk);
    chk("R4 released", dreq, 1'b1);

    // R4 restart and R5 read strobe, read direction
    dir_rd = 1'b1; fifo_empty = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 32; k++) ack(1'b0);
    chk("R3 cap read dir", dreq, 1'b0);
    chk("R5 rd strobe", last_rd, 1'b1);
    repeat (8) @(negedge clk);
    ack(1'b0);
    chk("R5 rd strobe without request", last_rd, 1'b1);
    repeat (HOLD_B - 1) @(negedge clk);
    chk("R4 restart held", dreq, 1'b0);
    @(negedge clk);
    chk("R4 restart released", dreq, 1'b1);

    // R8: burst count restarts on a drop
    for (int k = 0; k < 20; k++) ack(1'b0);
    fifo_empty = 1'b1;
    @(negedge clk);
    chk("R2 empty drops", dreq, 1'b0);
    fifo_empty = 1'b0;
    @(negedge clk);
    chk("R2 refill", dreq, 1'b1);
    for (int k = 0; k < 31; k++) ack(1'b0);
    chk("R8 fresh burst", dreq, 1'b1);
    ack(1'b0);
    chk("R3 cap after restart", dreq, 1'b0);
    repeat (HOLD_B + 1) @(negedge clk);
    chk("R4 back", dreq, 1'b1);

    // R6: terminal count
    ack(1'b0);
    ack(1'b1);
    chk("R6 tc_done", last_tc, 1'b1);
    chk("R6 drop", dreq, 1'b0);
    chk("R6 pulse ends", tc_done, 1'b0);
    repeat (5) @(negedge clk);
    chk("R6 blocked", dreq, 1'b0);
    svc_hold = 1'b1;
    @(negedge clk);
    svc_hold = 1'b0;
    @(negedge clk);
    chk("R6 resume", dreq, 1'b1);

    // R7: enable cleared
    for (int k = 0; k < 3; k++) ack(1'b0);
    dma_en = 1'b0;
    @(negedge clk);
    chk("R7 drop", dreq, 1'b0);
    ack(1'b0);
    chk("R7 no tc_done", last_tc, 1'b0);
    chk("R7 stays low", dreq, 1'b0);
    dma_en = 1'b1;
    @(negedge clk);
    chk("R7 re-enable", dreq, 1'b1);

    // R9: reset mid transfer
    rst_n = 1'b0;
    #1;
    chk("R9 async reset", dreq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done_run = 1'b1;
    finish_run();
  end
endmodule